// File: doc/BRIEF.md
# Time-Multiplexed LUT Compute Element

This block evaluates a partitioned logic netlist over several clock cycles with a single function-table memory. The memory acts as a bank of lookup tables with many inputs and several outputs. Each partition is one step of a stored microcode schedule, and the steps run in topological order. In every step an operand network gathers address bits from a small register file of earlier results and from the primary inputs. The step adds these bits to a per-step table base and reads one function-table word. That word is written back into the register file and can also be sent out as a primary output.

Software first loads the function table and the schedule through a configuration stream while the element is idle. It then pulses `start`. The sequencer walks the schedule from entry 0 to the entry flagged last, pulses `done` and goes idle again. The primary inputs are a plain vector and must be held steady for a whole run. Results marked for output leave on a valid/ready stream. When the stream is back-pressured, the element holds the word and stalls its schedule until the word is taken. The configuration stream has its own rule: `cfg_ready` is low during a run, and a beat offered then is not taken and has no effect.

Top module: `tm_lut_core`

## Requirements
- R1: After reset `busy`, `done` and `po_valid` are low, `cfg_ready` is high, and every register-file entry reads as zero.
- R2: A configuration beat is taken when `cfg_valid` and `cfg_ready` are both high. With `cfg_target`=0 it writes `cfg_data[3:0]` to function-table word `cfg_addr`. With `cfg_target`=1 it writes all of `cfg_data` to schedule entry `cfg_addr[3:0]`.
- R3: The microcode word layout is as follows. Bit 0 is the last-step flag and bit 1 is the output enable. Bits 4:2 hold the destination register. Address select i (i = 0..11) sits at bits 5+6i .. 10+6i, and the table base sits at bits 88:77. A select value s from 0 to 31 picks register-file bit s, which is bit s%4 of entry s/4. A value from 32 to 39 picks primary input bit s-32. Any other value gives a constant 0.
- R4: A step reads function-table word (base + operand) mod 4096, where the operand is the 12 selected bits with select 0 as its LSB.
- R5: Each completed step writes its 4-bit result into the destination register, and later steps of the same run see the new value.
- R6: When a step has its output enable set, `po_valid` is high with the result on `po_data`. Both stay unchanged until `po_ready` is high, and the schedule does not advance before that.
- R7: Each step takes two cycles. With a start pulse sampled at edge 0 and no stalls, step k's result is present after edge 2k+1. `done` is high for exactly the one cycle that follows the last step's final edge (after edge 2n for n steps), and then `busy` is low.
- R8: A start pulse always restarts at schedule entry 0, even in the middle of a run. The step that is interrupted writes nothing.
- R9: During a run `cfg_ready` is low, and configuration beats change neither the function table nor the schedule.
- R10: The function table is never read while configuration can write it, and no output is offered outside a run.
- R11: Register-file contents are cleared only by reset and carry over from one run to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin evaluation at schedule entry 0 |
| busy | output | 1 | Schedule is being evaluated |
| done | output | 1 | One-cycle pulse after the last step |
| pi | input | 8 | Primary inputs, held steady during a run |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_ready | output | 1 | Configuration beat can be taken (idle) |
| cfg_target | input | 1 | 0 = function table, 1 = schedule table |
| cfg_addr | input | 12 | Word or entry index |
| cfg_data | input | 89 | Table word (low 4 bits) or microcode word |
| po_valid | output | 1 | Primary output word offered |
| po_ready | input | 1 | Primary output word accepted |
| po_data | output | 4 | Primary output word |

## Verification
All timing is counted from the edge that samples `start`. Step k's output word is due in the cycle after edge 2k+1. `done` is due after edge 2n, plus one cycle for each cycle the output was held back. The bench drives inputs and samples outputs on falling edges, and it counts those falling edges from the start pulse. It checks every output handshake and the `done` cycle against these exact counts. The expected words come from a closed-form function that the bench also uses to fill the function table, so each result is computed from the address that R3 and R4 define.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} tlc_state_e;
  typedef enum logic {PH_ADDR, PH_WB} tlc_phase_e;

  function automatic int sel_width(input int rf_bits, input int pi_w);
    return $clog2(rf_bits + pi_w + 1);
  endfunction
endpackage

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
  import tlc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int UW     = 89,
  parameter int SCH_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sch_we,
  input  logic [SCH_AW-1:0] sch_waddr,
  input  logic [UW-1:0]     sch_wdata,
  input  logic              stall,
  output logic [UW-1:0]     uword,
  output logic [SCH_AW-1:0] pc,
  output logic              read_en,
  output logic              commit,
  output logic              wb_phase,
  output logic              busy,
  output logic              done
);
  logic [UW-1:0] table_q [DEPTH];
  tlc_state_e    state;
  tlc_phase_e    phase;

  always_ff @(posedge clk) begin
    if (sch_we) table_q[sch_waddr] <= sch_wdata;
  end

  assign uword    = table_q[pc];
  assign busy     = (state == ST_RUN);
  assign done     = (state == ST_DONE);
  assign wb_phase = busy && (phase == PH_WB);
  assign read_en  = busy && (phase == PH_ADDR);
  assign commit   = wb_phase && !stall && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_ADDR;
      pc    <= '0;
    end else if (start) begin
      state <= ST_RUN;
      phase <= PH_ADDR;
      pc    <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (phase == PH_ADDR) begin
            phase <= PH_WB;
          end else if (!stall) begin
            phase <= PH_ADDR;
            if (uword[0]) begin
              state <= ST_DONE;
              pc    <= '0;
            end else begin
              pc <= pc + SCH_AW'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlc_operand_mux.sv
module tlc_operand_mux #(
  parameter int LUT_IN  = 12,
  parameter int RF_BITS = 32,
  parameter int PI_W    = 8,
  parameter int SEL_W   = 6
) (
  input  logic [LUT_IN*SEL_W-1:0] sels,
  input  logic [RF_BITS-1:0]      rf_flat,
  input  logic [PI_W-1:0]         pi,
  output logic [LUT_IN-1:0]       operand
);
  localparam int NSRC = RF_BITS + PI_W;

  logic [NSRC-1:0] src;
  assign src = {pi, rf_flat};

  for (genvar i = 0; i < LUT_IN; i++) begin : g_bit
    logic [SEL_W-1:0] s;
    assign s          = sels[i*SEL_W +: SEL_W];
    assign operand[i] = (int'(s) < NSRC) ? src[s] : 1'b0;
  end
endmodule

// File: rtl/tlc_regfile.sv
module tlc_regfile #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [W-1:0]       wdata,
  output logic [DEPTH*W-1:0] rf_flat
);
  logic [W-1:0] ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) ent[j] <= '0;
    end else if (we) begin
      ent[waddr] <= wdata;
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_flat
    assign rf_flat[j*W +: W] = ent[j];
  end
endmodule

// File: rtl/tlc_ftable.sv
module tlc_ftable #(
  parameter int AW = 12,
  parameter int W  = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tm_lut_core.sv
module tm_lut_core
  import tlc_pkg::*;
#(
  parameter int LUT_IN      = 12,
  parameter int LUT_OUT     = 4,
  parameter int RF_DEPTH    = 8,
  parameter int PI_W        = 8,
  parameter int SCHED_DEPTH = 16,
  parameter int FT_AW       = 12
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  output logic                                    busy,
  output logic                                    done,
  input  logic [PI_W-1:0]                         pi,
  input  logic                                    cfg_valid,
  output logic                                    cfg_ready,
  input  logic                                    cfg_target,
  input  logic [((FT_AW > $clog2(SCHED_DEPTH)) ? FT_AW : $clog2(SCHED_DEPTH))-1:0] cfg_addr,
  input  logic [FT_AW + LUT_IN*sel_width(RF_DEPTH*LUT_OUT, PI_W) + $clog2(RF_DEPTH) + 1:0] cfg_data,
  output logic                                    po_valid,
  input  logic                                    po_ready,
  output logic [LUT_OUT-1:0]                      po_data
);
  localparam int RF_BITS = RF_DEPTH * LUT_OUT;
  localparam int SEL_W   = sel_width(RF_BITS, PI_W);
  localparam int DST_W   = $clog2(RF_DEPTH);
  localparam int SCH_AW  = $clog2(SCHED_DEPTH);
  localparam int SELS_W  = LUT_IN * SEL_W;
  localparam int UW      = FT_AW + SELS_W + DST_W + 2;

  logic [UW-1:0]      uword;
  logic [SCH_AW-1:0]  seq_pc;
  logic               ft_re, ft_we, sch_we, commit, wb_phase, stall;
  logic [RF_BITS-1:0] rf_flat;
  logic [LUT_IN-1:0]  operand;
  logic [FT_AW-1:0]   ft_raddr;
  logic [LUT_OUT-1:0] ft_rdata;

  wire                 u_oe   = uword[1];
  wire [DST_W-1:0]     u_dst  = uword[2 +: DST_W];
  wire [SELS_W-1:0]    u_sels = uword[2+DST_W +: SELS_W];
  wire [FT_AW-1:0]     u_base = uword[UW-1 -: FT_AW];

  assign cfg_ready = !busy;
  assign ft_we     = cfg_valid && cfg_ready && !cfg_target;
  assign sch_we    = cfg_valid && cfg_ready && cfg_target;
  assign po_valid  = wb_phase && u_oe;
  assign po_data   = ft_rdata;
  assign stall     = po_valid && !po_ready;
  assign ft_raddr  = u_base + FT_AW'(operand);

  tlc_sequencer #(.DEPTH(SCHED_DEPTH), .UW(UW), .SCH_AW(SCH_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sch_we(sch_we), .sch_waddr(cfg_addr[SCH_AW-1:0]), .sch_wdata(cfg_data),
    .stall(stall), .uword(uword), .pc(seq_pc), .read_en(ft_re),
    .commit(commit), .wb_phase(wb_phase), .busy(busy), .done(done)
  );

  tlc_operand_mux #(.LUT_IN(LUT_IN), .RF_BITS(RF_BITS), .PI_W(PI_W), .SEL_W(SEL_W)) u_mux (
    .sels(u_sels), .rf_flat(rf_flat), .pi(pi), .operand(operand)
  );

  tlc_ftable #(.AW(FT_AW), .W(LUT_OUT)) u_ft (
    .clk(clk), .we(ft_we), .waddr(cfg_addr[FT_AW-1:0]), .wdata(cfg_data[LUT_OUT-1:0]),
    .re(ft_re), .raddr(ft_raddr), .rdata(ft_rdata)
  );

  tlc_regfile #(.DEPTH(RF_DEPTH), .W(LUT_OUT)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(u_dst),
    .wdata(ft_rdata), .rf_flat(rf_flat)
  );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int LUT_OUT = 4,
  parameter int SCH_AW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               cfg_ready,
  input logic               po_valid,
  input logic               po_ready,
  input logic [LUT_OUT-1:0] po_data,
  input logic               ft_we,
  input logic               ft_re,
  input logic [SCH_AW-1:0]  pc
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R7
  AST_PO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (po_valid && !po_ready && !start) |=> (po_valid && $stable(po_data))); // R6
  AST_START_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && pc == '0)); // R8
  AST_NO_CFG_WRITE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ft_we); // R9
  AST_NO_READ_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ft_re |-> (!ft_we && !cfg_ready)); // R10
  AST_QUIET_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !po_valid); // R10
endmodule

bind tm_lut_core tlc_checker #(.LUT_OUT(LUT_OUT), .SCH_AW(SCH_AW)) u_tlc_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_ready(cfg_ready), .po_valid(po_valid), .po_ready(po_ready),
  .po_data(po_data), .ft_we(ft_we), .ft_re(ft_re), .pc(seq_pc)
);

// File: tb/test_tm_lut_core.sv
`timescale 1ns/1ps
module test_tm_lut_core;
  localparam int UW = 89;

  logic          clk = 0, rst_n = 0, start = 0;
  logic          busy, done, cfg_ready, po_valid;
  logic [7:0]    pi = '0;
  logic          cfg_valid = 0, cfg_target = 0, po_ready = 1;
  logic [11:0]   cfg_addr = '0;
  logic [UW-1:0] cfg_data = '0;
  logic [3:0]    po_data;
  int checks = 0, errors = 0;

  tm_lut_core i_tm_lut_core (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pi(pi),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_target(cfg_target),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .po_valid(po_valid), .po_ready(po_ready), .po_data(po_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fval(input int a);
    return ((a * 5) + (a >> 6)) & 15;
  endfunction

  function automatic logic [71:0] zsel();
    return {12{6'd63}};
  endfunction

  function automatic logic [UW-1:0] mkw(input int base, input logic [71:0] s,
                                        input int dst, input bit oe, input bit last);
    return {12'(base), s, 3'(dst), oe, last};
  endfunction

  task automatic cfg_write(input bit tgt, input int addr, input logic [UW-1:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_target = tgt; cfg_addr = 12'(addr); cfg_data = d;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  // Runs the loaded schedule; checks outputs, their first cycle and the done cycle.
  task automatic do_run(input string req, input int nexp, input int e0, input int e1,
                        input int first_cyc, input int done_cyc,
                        input int stall_idx, input int stall_len, input bit ign);
    int k = 0, stalled = 0, cyc = 1, got_done = -1, got_first = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (cyc < 60 && got_done < 0) begin
      po_ready = 1;
      if (ign && cyc == 1) begin
        chk("R9 cfg_ready low in run", cfg_ready, 0);
        cfg_valid = 1; cfg_target = 0; cfg_addr = 12'd4; cfg_data = UW'(fval(4) ^ 15);
      end else if (ign && cyc == 3) begin
        cfg_valid = 1; cfg_target = 1; cfg_addr = 12'd0; cfg_data = '0;
      end else cfg_valid = 0;
      if (po_valid) begin
        if (got_first < 0) got_first = cyc;
        if (k == stall_idx && stalled < stall_len) begin
          po_ready = 0; stalled++;
        end else begin
          chk({req, " output word"}, po_data, (k == 0) ? e0 : e1);
          k++;
        end
      end
      if (done) got_done = cyc;
      @(negedge clk); cyc++;
    end
    po_ready = 1; cfg_valid = 0;
    chk({req, " R6 output count"}, k, nexp);
    chk({req, " R7 first output cycle"}, got_first, first_cyc);
    chk({req, " R7 done cycle"}, got_done, done_cyc);
    chk({req, " R7 idle after done"}, {busy, done, cfg_ready}, 3'b001);
  endtask

  // three-step program using pi and chained registers
  task automatic load_p1();
    logic [71:0] s0 = zsel(), s1 = zsel(), s2 = zsel();
    for (int i = 0; i < 8; i++) s0[6*i +: 6] = 6'(32 + i);
    for (int i = 0; i < 4; i++) begin
      s1[6*i +: 6] = 6'(4 + i); s1[6*(i+4) +: 6] = 6'(32 + i);
      s2[6*i +: 6] = 6'(8 + i); s2[6*(i+8) +: 6] = 6'(4 + i);
    end
    cfg_write(1, 0, mkw(4090, s0, 1, 1, 0));
    cfg_write(1, 1, mkw(300, s1, 2, 0, 0));
    cfg_write(1, 2, mkw(0, s2, 3, 1, 1));
  endtask

  function automatic int p1_r2(input int p);
    int r1 = fval((4090 + p) & 4095);
    return fval(300 + r1 + (p & 15) * 16);
  endfunction
  function automatic int p1_out(input int p);
    return fval(p1_r2(p) + fval((4090 + p) & 4095) * 256);
  endfunction

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 po_valid", po_valid, 0); chk("R1 cfg_ready", cfg_ready, 1);
  endtask

  task automatic t_load_ft();
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      cfg_valid = 1; cfg_target = 0; cfg_addr = 12'(a); cfg_data = UW'(fval(a));
    end
    @(negedge clk); cfg_valid = 0;
  endtask

  task automatic t_rf_zero();
    logic [71:0] s;
    for (int i = 0; i < 12; i++) s[6*i +: 6] = 6'(i);
    cfg_write(1, 0, mkw(100, s, 7, 1, 1));
    do_run("R1 R2 R4 zero regfile", 1, fval(100), 0, 2, 3, -1, 0, 0);
  endtask

  task automatic t_chain(input int p);
    pi = 8'(p);
    do_run("R3 R4 R5 chain", 2, fval((4090 + p) & 4095), p1_out(p), 2, 7, -1, 0, 0);
  endtask

  task automatic t_stall();
    pi = 8'h0A;
    do_run("R6 back-pressure", 2, fval(4), p1_out(10), 2, 10, 1, 3, 0);
  endtask

  task automatic t_cfg_ignored();
    pi = 8'h0A;
    do_run("R9 during run", 2, fval(4), p1_out(10), 2, 7, -1, 0, 1);
    do_run("R9 tables intact", 2, fval(4), p1_out(10), 2, 7, -1, 0, 0);
  endtask

  task automatic t_persist();
    logic [71:0] s = zsel();
    for (int i = 0; i < 4; i++) s[6*i +: 6] = 6'(12 + i);
    cfg_write(1, 0, mkw(7, s, 0, 1, 1));
    do_run("R11 regfile kept", 1, fval(7 + p1_out(10)), 0, 2, 3, -1, 0, 0);
  endtask

  task automatic t_restart();
    load_p1();
    pi = 8'h3C;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    do_run("R8 restart", 2, fval((4090 + 60) & 4095), p1_out(60), 2, 7, -1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_ft();
    t_rf_zero();
    load_p1();
    t_chain(8'h0A);
    t_chain(8'h3C);
    t_stall();
    t_cfg_ignored();
    t_persist();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule